// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two signed 16-bit operands (the width is a parameter) over a fixed number of clock cycles. It handles one multiplier bit per iteration. A high accumulator receives the multiplicand whenever the current multiplier bit is set. The accumulator is then shifted right into a low shift register. The low register starts with a single marker bit in its most significant position, and the loop stops when that marker falls out of the bottom. No separate iteration counter is used. After the loop, the multiplicand is subtracted once from the accumulator if the multiplier was negative. This turns the unsigned-multiplier loop into a signed product.

The result goes to a register pair named by a destination register number. When that number is even, the high word goes to it and the low word goes to the next odd register. When it is odd, only the low word is written, to that register. Four condition flags are produced along with the result, and a one-cycle done strobe marks that the result is valid.

The control state machine has three states:

| State | Role |
|---|---|
| `S_IDLE` | Waits for start. |
| `S_ITER` | Runs one shift-add step per cycle. |
| `S_FIX` | Applies the sign correction and registers the result. |

It has three transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| Launch | `S_IDLE` | `S_ITER` | start sampled high |
| Loop end | `S_ITER` | `S_FIX` | marker at the bottom of the low register |
| Retire | `S_FIX` | `S_IDLE` | unconditional |

Top module: `smul_top`

## Requirements
- R1: After reset, `done` is low and all four flag outputs are low.
- R2: For any pair of signed operands, the 32-bit value {`hi_data`,`lo_data`} equals the two's-complement product `mcand * mplier`.
- R3: `done` rises exactly W+1 rising edges after the edge that samples `start` in idle (17 for W=16), whatever the operand values, and stays high for exactly one cycle.
- R4: A `start` pulse while a multiply is in progress is ignored. Its operands and destination do not affect the result, the destination or the timing of the running multiply.
- R5: With an even destination number r, `hi_wr_en` is 1, `hi_sel` equals r and `lo_sel` equals r with bit 0 set.
- R6: With an odd destination number r, `hi_wr_en` is 0 and `lo_sel` equals r.
- R7: `flag_n` equals bit 31 of the product, and `flag_z` is 1 only when all 32 product bits are zero.
- R8: `flag_v` is always 0 when `done` is high.
- R9: `flag_c` is 1 exactly when the high word is not the sign extension of bit 15 of the low word, that is, when the product does not fit in a signed 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, sampled in idle only |
| mcand | input | 16 | Multiplicand (signed) |
| mplier | input | 16 | Multiplier (signed) |
| dst | input | 3 | Destination register number |
| done | output | 1 | One-cycle result strobe |
| hi_wr_en | output | 1 | High word write enable (even destination) |
| hi_sel | output | 3 | Register number for the high word |
| hi_data | output | 16 | High product word |
| lo_sel | output | 3 | Register number for the low word |
| lo_data | output | 16 | Low product word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag (cleared) |
| flag_c | output | 1 | Product exceeds 16 signed bits |

## Verification
The hardest internal situation to reach is an accumulator add that overflows 16 bits. In that case the right shift must bring the true sign back in, rather than copying the wrong sign bit. Overflow needs both operands near full scale with the same sign. For that reason, the sweep crosses 64 operand values against each other: powers of two, their complements, all-ones masks and scrambled patterns. This set includes 0x8000 times 0x8000 and 0x7FFF times 0x7FFF. A second start is also injected mid-loop on every operation. This shows that a busy multiply cannot be disturbed.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ITER = 2'd1,
        S_FIX  = 2'd2
    } smul_state_t;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic last,
    output logic load,
    output logic step,
    output logic fix
);
    localparam int CW = $clog2(W + 1) + 1;

    smul_state_t state, nxt;
    logic [CW-1:0] it_cnt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic: launch, loop end, retire
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = S_ITER;
            S_ITER: if (last)  nxt = S_FIX;
            S_FIX:             nxt = S_IDLE;
            default:           nxt = S_IDLE;
        endcase
    end

    // Decoded controls
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        fix  = 1'b0;
        unique case (state)
            S_IDLE: load = start;
            S_ITER: step = 1'b1;
            S_FIX:  fix  = 1'b1;
            default: ;
        endcase
    end

    // Iteration tally used only to cross-check the marker-terminated loop
    always_ff @(posedge clk) begin
        if (!rst_n)    it_cnt <= '0;
        else if (load) it_cnt <= '0;
        else if (step) it_cnt <= it_cnt + 1'b1;
    end

    // R3: the marker ends the loop after exactly W steps
    a_r3_marker_span: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ITER && last) |-> (it_cnt == CW'(W - 1)));

    // R4: a running loop only leaves through the marker
    a_r4_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ITER && !last) |=> (state == S_ITER));
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         last,
    output logic [W-1:0] fin_hi,
    output logic [W-1:0] fin_lo
);
    localparam logic [W-1:0] MARKER = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] acc, lo_sr, mq, mc;
    logic         mneg;
    logic [W:0]   sum;

    // Conditional add, widened by one bit so an overflowing add keeps its true sign
    always_comb begin
        if (mq[0]) sum = {acc[W-1], acc} + {mc[W-1], mc};
        else       sum = {acc[W-1], acc};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc   <= '0;
            lo_sr <= '0;
            mq    <= '0;
            mc    <= '0;
            mneg  <= 1'b0;
        end else if (load) begin
            acc   <= '0;
            lo_sr <= MARKER;
            mq    <= mplier;
            mc    <= mcand;
            mneg  <= mplier[W-1];
        end else if (step) begin
            acc   <= sum[W:1];
            lo_sr <= {sum[0], lo_sr[W-1:1]};
            mq    <= {1'b0, mq[W-1:1]};
        end
    end

    // The marker reaching bit 0 means this step is the final one
    assign last   = lo_sr[0];
    assign fin_hi = mneg ? (acc - mc) : acc;
    assign fin_lo = lo_sr;
endmodule

// File: rtl/smul_wb.sv
module smul_wb #(
    parameter int W  = 16,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          fix,
    input  logic [RW-1:0] dst,
    input  logic [W-1:0]  fin_hi,
    input  logic [W-1:0]  fin_lo,
    output logic          done,
    output logic          hi_wr_en,
    output logic [RW-1:0] hi_sel,
    output logic [W-1:0]  hi_data,
    output logic [RW-1:0] lo_sel,
    output logic [W-1:0]  lo_data,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    logic [RW-1:0] dst_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    dst_q <= '0;
        else if (load) dst_q <= dst;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            hi_wr_en <= 1'b0;
            hi_sel   <= '0;
            lo_sel   <= '0;
            hi_data  <= '0;
            lo_data  <= '0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_v   <= 1'b0;
            flag_c   <= 1'b0;
        end else begin
            done <= fix;
            if (fix) begin
                hi_data  <= fin_hi;
                lo_data  <= fin_lo;
                hi_wr_en <= ~dst_q[0];
                hi_sel   <= dst_q;
                lo_sel   <= dst_q | RW'(1);
                flag_n   <= fin_hi[W-1];
                flag_z   <= (fin_hi == '0) && (fin_lo == '0);
                flag_v   <= 1'b0;
                flag_c   <= (fin_hi != {W{fin_lo[W-1]}});
            end
        end
    end

    // R3: done lasts a single cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: an even pair targets adjacent registers
    a_r5_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hi_wr_en) |-> (lo_sel == (hi_sel | RW'(1)) && !hi_sel[0]));

    // R7: a zero product is neither negative nor oversize
    a_r7_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flag_z) |-> (!flag_n && !flag_c));
endmodule

// File: rtl/smul_top.sv
module smul_top #(
    parameter int W  = 16,
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  mcand,
    input  logic [W-1:0]  mplier,
    input  logic [RW-1:0] dst,
    output logic          done,
    output logic          hi_wr_en,
    output logic [RW-1:0] hi_sel,
    output logic [W-1:0]  hi_data,
    output logic [RW-1:0] lo_sel,
    output logic [W-1:0]  lo_data,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    logic load, step, fix, last;
    logic [W-1:0] fin_hi, fin_lo;

    smul_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .last(last),
        .load(load), .step(step), .fix(fix)
    );

    smul_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .mcand(mcand), .mplier(mplier), .last(last),
        .fin_hi(fin_hi), .fin_lo(fin_lo)
    );

    smul_wb #(.W(W), .RW(RW)) u_wb (
        .clk(clk), .rst_n(rst_n), .load(load), .fix(fix), .dst(dst),
        .fin_hi(fin_hi), .fin_lo(fin_lo), .done(done),
        .hi_wr_en(hi_wr_en), .hi_sel(hi_sel), .hi_data(hi_data),
        .lo_sel(lo_sel), .lo_data(lo_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // R8: overflow flag stays clear on every result
    a_r8_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flag_v);
endmodule

// File: tb/smul_top_tb.sv
module smul_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] mcand = '0, mplier = '0;
    logic [2:0]  dst = '0;
    logic        done, hi_wr_en, flag_n, flag_z, flag_v, flag_c;
    logic [2:0]  hi_sel, lo_sel;
    logic [15:0] hi_data, lo_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    smul_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand), .mplier(mplier),
        .dst(dst), .done(done), .hi_wr_en(hi_wr_en), .hi_sel(hi_sel),
        .hi_data(hi_data), .lo_sel(lo_sel), .lo_data(lo_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int k);
        if (k < 16)      pat = 16'(1 << k);
        else if (k < 32) pat = ~16'(1 << (k - 16));
        else if (k < 48) pat = 16'((1 << (k - 32)) - 1);
        else             pat = 16'(k * 40503 + 17);
    endfunction

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic [2:0] r);
        int          e;
        logic [31:0] ep;
        int          cyc;
        e  = int'($signed(a)) * int'($signed(b));
        ep = 32'(e);
        @(negedge clk);
        mcand = a; mplier = b; dst = r; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (cyc == 5) begin
                // R4: disturbing start while busy
                mcand = ~a; mplier = b ^ 16'h5a5a; dst = ~r; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        chk(cyc == 17, "R3 latency", cyc, 17);
        chk({hi_data, lo_data} == ep, "R2/R4 product", {hi_data, lo_data}, ep);
        if (!r[0])
            chk(hi_wr_en && hi_sel == r && lo_sel == (r | 3'd1), "R5 even dest",
                {hi_wr_en, hi_sel, lo_sel}, {1'b1, r, r | 3'd1});
        else
            chk(!hi_wr_en && lo_sel == r, "R6 odd dest", {hi_wr_en, lo_sel}, {1'b0, r});
        chk(flag_n == ep[31] && flag_z == (ep == 0), "R7 n/z",
            {flag_n, flag_z}, {ep[31], ep == 0});
        chk(!flag_v, "R8 v clear", flag_v, 0);
        chk(flag_c == (e > 32767 || e < -32768), "R9 carry",
            flag_c, (e > 32767 || e < -32768));
        @(negedge clk);
        chk(!done, "R3 pulse width", done, 0);
    endtask

    initial begin
        #1_200_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!done && !flag_n && !flag_z && !flag_v && !flag_c, "R1 reset",
            {done, flag_n, flag_z, flag_v, flag_c}, 0);
        for (int i = 0; i < 64; i++)
            for (int j = 0; j < 64; j++)
                run_op(pat(i), pat(j), 3'(i + j));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule